// File: doc/BRIEF.md
# Indexed Multi-Channel PWM Register Bank

This block is the register front end of a ten-channel PWM peripheral. Software sees two words. One is a 16-bit control word that holds a global enable, a self-clearing commit strobe, a channel index and a register index. The other is a data port that reaches one per-channel register at a time, chosen by those two indices. Each channel owns three 16-bit registers: a duty value, a configuration value and a delay value.

Duty values are double-buffered. A data-port write lands in a pending copy. The active copy that drives the waveform generator changes only when the commit strobe is set, and then all channels change together. Configuration and delay writes take effect at once. After every data-port access the channel index steps forward by one, so software can stream the same register of all channels without rewriting the control word.

The block drives the active duty, configuration and delay values of every channel as flat vectors, together with the global enable. The waveform generators that use these values are outside this block.

Top module: `pwm_regbank`

## Requirements
- R1: After reset the control word reads 0, `pwm_en_o` is 0, and every pending duty, active duty, configuration and delay value is 0.
- R2: The control word has the global enable at bit 12, the commit strobe at bit 8, the channel index at bits 7:4 and the register index at bits 1:0. All other bits read 0, and writes to them are discarded.
- R3: `pwm_en_o` equals control bit 12 from the cycle after the control write that sets it.
- R4: A duty write (register index 0) changes only the pending copy. `duty_o` does not change, and a data-port read of a duty register returns the pending value.
- R5: A control write with bit 8 set makes bit 8 read 1 for exactly one cycle. At the end of that cycle every channel's active duty takes its pending value, and then bit 8 reads 0.
- R6: Register index 1 selects configuration, and indexes 2 and 3 both select delay. Writes to these registers appear on `cfg_o` or `dly_o` in the next cycle.
- R7: Each data-port access (read, write, or both in one cycle) advances the channel index by one. From 9, or from a reserved value of 10 to 15, it wraps to 0.
- R8: At a reserved channel index (10 to 15) the data port reads 0 and writes change no register.
- R9: When a control write and a data access fall in the same cycle, the access uses the old indices, and the channel index takes the written value with no increment.
- R10: A duty write in the cycle in which bit 8 reads 1 stays pending. The commit moves the previous pending value, and the new value needs a later commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 16 | Control word write data |
| ctl_rdata_o | output | 16 | Control word read data |
| dat_we_i | input | 1 | Data port write strobe |
| dat_re_i | input | 1 | Data port read strobe (advances index) |
| dat_wdata_i | input | 16 | Data port write data |
| dat_rdata_o | output | 16 | Data port read data at the current indices |
| pwm_en_o | output | 1 | Global enable for all channels |
| duty_o | output | 160 | Active duty values, channel n at bits 16n+15:16n |
| cfg_o | output | 160 | Configuration values, same packing |
| dly_o | output | 160 | Delay values, same packing |

## Verification
Two pairs of functions can fall in the same cycle here. The first pair is the commit strobe and a duty write. The bench issues a duty write in the single cycle in which bit 8 reads 1, then checks that the active duty holds the older pending value, and that the new value appears only after a second commit. The second pair is a control write and a data access. The bench issues both in one cycle and checks that the data lands at the old channel and register, while the channel index shows the written value and not the written value plus one.

// File: rtl/pwm_regbank_pkg.sv
package pwm_regbank_pkg;
  localparam int CTL_W   = 16;
  localparam int EN_BIT  = 12;
  localparam int UPD_BIT = 8;
  localparam int CH_LSB  = 4;
  localparam int CH_W    = 4;
  localparam int RS_LSB  = 0;
  localparam int RS_W    = 2;

  typedef enum logic [1:0] {
    RK_DUTY = 2'd0,
    RK_CFG  = 2'd1,
    RK_DLY  = 2'd2
  } reg_kind_e;

  typedef struct packed {
    logic            en;
    logic            upd;
    logic [CH_W-1:0] ch;
    logic [RS_W-1:0] rs;
  } ctl_t;

  function automatic reg_kind_e kind_of(input logic [RS_W-1:0] rs);
    if (rs == 2'd0)      return RK_DUTY;
    else if (rs == 2'd1) return RK_CFG;
    else                 return RK_DLY;
  endfunction
endpackage

// File: rtl/pwm_ctl_reg.sv
module pwm_ctl_reg
  import pwm_regbank_pkg::*;
#(
  parameter int CH_N = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             access_i,
  output ctl_t             ctl_o,
  output logic [CTL_W-1:0] ctl_rdata_o
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(CH_N - 1);

  ctl_t            ctl_q;
  logic [CH_W-1:0] ch_next;
  logic            unused_rsv;

  // wrap from last channel and from any reserved index
  assign ch_next = (ctl_q.ch >= LAST_CH) ? '0 : ctl_q.ch + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (ctl_we_i) begin
      ctl_q.en  <= ctl_wdata_i[EN_BIT];
      ctl_q.upd <= ctl_wdata_i[UPD_BIT];
      ctl_q.ch  <= ctl_wdata_i[CH_LSB +: CH_W];
      ctl_q.rs  <= ctl_wdata_i[RS_LSB +: RS_W];
    end else begin
      ctl_q.upd <= 1'b0;
      if (access_i) ctl_q.ch <= ch_next;
    end
  end

  always_comb begin
    ctl_rdata_o                 = '0;
    ctl_rdata_o[EN_BIT]         = ctl_q.en;
    ctl_rdata_o[UPD_BIT]        = ctl_q.upd;
    ctl_rdata_o[CH_LSB +: CH_W] = ctl_q.ch;
    ctl_rdata_o[RS_LSB +: RS_W] = ctl_q.rs;
  end

  assign unused_rsv = ^{ctl_wdata_i[15:13], ctl_wdata_i[11:9], ctl_wdata_i[3:2]};
  assign ctl_o      = ctl_q;

  AST_UPD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.upd && !(ctl_we_i && ctl_wdata_i[UPD_BIT]) |=> !ctl_q.upd); // R5
  AST_CH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_i && !ctl_we_i && (ctl_q.ch < LAST_CH) |=>
      ctl_q.ch == CH_W'($past(ctl_q.ch) + 1'b1)); // R7
  AST_CH_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_i && !ctl_we_i && (ctl_q.ch >= LAST_CH) |=> ctl_q.ch == '0); // R7
  AST_CTL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> ctl_q.ch == $past(ctl_wdata_i[CH_LSB +: CH_W])); // R9
endmodule

// File: rtl/pwm_addr_dec.sv
module pwm_addr_dec
  import pwm_regbank_pkg::*;
#(
  parameter int CH_N = 10
) (
  input  logic [CH_W-1:0] ch_i,
  input  logic [RS_W-1:0] rs_i,
  input  logic            wr_i,
  output reg_kind_e       kind_o,
  output logic [CH_N-1:0] hit_o,
  output logic [CH_N-1:0] duty_we_o,
  output logic [CH_N-1:0] cfg_we_o,
  output logic [CH_N-1:0] dly_we_o
);
  assign kind_o = kind_of(rs_i);

  // reserved indices match no channel, so nothing is written there
  for (genvar i = 0; i < CH_N; i++) begin : g_hit
    assign hit_o[i]     = (ch_i == CH_W'(i));
    assign duty_we_o[i] = wr_i && hit_o[i] && (kind_o == RK_DUTY);
    assign cfg_we_o[i]  = wr_i && hit_o[i] && (kind_o == RK_CFG);
    assign dly_we_o[i]  = wr_i && hit_o[i] && (kind_o == RK_DLY);
  end
endmodule

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              duty_we_i,
  input  logic              cfg_we_i,
  input  logic              dly_we_i,
  input  logic              commit_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] duty_pend_o,
  output logic [DATA_W-1:0] duty_act_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic [DATA_W-1:0] dly_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_pend_o <= '0;
      duty_act_o  <= '0;
      cfg_o       <= '0;
      dly_o       <= '0;
    end else begin
      // commit samples the pending copy from before this edge
      if (commit_i)  duty_act_o  <= duty_pend_o;
      if (duty_we_i) duty_pend_o <= wdata_i;
      if (cfg_we_i)  cfg_o       <= wdata_i;
      if (dly_we_i)  dly_o       <= wdata_i;
    end
  end

  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(duty_act_o)); // R4
  AST_ACT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> duty_act_o == $past(duty_pend_o)); // R10
endmodule

// File: rtl/pwm_regbank.sv
module pwm_regbank
  import pwm_regbank_pkg::*;
#(
  parameter int CH_N   = 10,
  parameter int DATA_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ctl_we_i,
  input  logic [CTL_W-1:0]         ctl_wdata_i,
  output logic [CTL_W-1:0]         ctl_rdata_o,
  input  logic                     dat_we_i,
  input  logic                     dat_re_i,
  input  logic [DATA_W-1:0]        dat_wdata_i,
  output logic [DATA_W-1:0]        dat_rdata_o,
  output logic                     pwm_en_o,
  output logic [CH_N*DATA_W-1:0]   duty_o,
  output logic [CH_N*DATA_W-1:0]   cfg_o,
  output logic [CH_N*DATA_W-1:0]   dly_o
);
  ctl_t              ctl;
  reg_kind_e         kind;
  logic              access;
  logic [CH_N-1:0]   hit, duty_we, cfg_we, dly_we;
  logic [DATA_W-1:0] rd_word [CH_N];

  assign access = dat_we_i | dat_re_i;

  pwm_ctl_reg #(.CH_N(CH_N)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_we_i    (ctl_we_i),
    .ctl_wdata_i (ctl_wdata_i),
    .access_i    (access),
    .ctl_o       (ctl),
    .ctl_rdata_o (ctl_rdata_o)
  );

  pwm_addr_dec #(.CH_N(CH_N)) u_dec (
    .ch_i      (ctl.ch),
    .rs_i      (ctl.rs),
    .wr_i      (dat_we_i),
    .kind_o    (kind),
    .hit_o     (hit),
    .duty_we_o (duty_we),
    .cfg_we_o  (cfg_we),
    .dly_we_o  (dly_we)
  );

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    logic [DATA_W-1:0] pend, act, cfg, dly;

    pwm_chan_regs #(.DATA_W(DATA_W)) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .duty_we_i   (duty_we[i]),
      .cfg_we_i    (cfg_we[i]),
      .dly_we_i    (dly_we[i]),
      .commit_i    (ctl.upd),
      .wdata_i     (dat_wdata_i),
      .duty_pend_o (pend),
      .duty_act_o  (act),
      .cfg_o       (cfg),
      .dly_o       (dly)
    );

    assign duty_o[i*DATA_W +: DATA_W] = act;
    assign cfg_o[i*DATA_W +: DATA_W]  = cfg;
    assign dly_o[i*DATA_W +: DATA_W]  = dly;

    always_comb begin
      rd_word[i] = '0;
      if (hit[i]) begin
        unique case (kind)
          RK_DUTY: rd_word[i] = pend;
          RK_CFG:  rd_word[i] = cfg;
          default: rd_word[i] = dly;
        endcase
      end
    end
  end

  always_comb begin
    dat_rdata_o = '0;
    for (int i = 0; i < CH_N; i++) dat_rdata_o |= rd_word[i];
  end

  assign pwm_en_o = ctl.en;

  AST_RSV_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rdata_o[CH_LSB +: CH_W] >= CH_W'(CH_N)) |-> dat_rdata_o == '0); // R8
  AST_EN_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> pwm_en_o == $past(ctl_wdata_i[EN_BIT])); // R3
endmodule

// File: tb/pwm_regbank_tb.sv
module pwm_regbank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 10;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           ctl_we, dat_we, dat_re;
  logic [15:0]    ctl_wdata, dat_wdata, ctl_rdata, dat_rdata;
  logic           pwm_en;
  logic [N*W-1:0] duty, cfg, dly;

  int n_chk = 0;
  int n_err = 0;

  logic [15:0] m_pend [N];
  logic [15:0] m_act  [N];
  logic [15:0] m_cfg  [N];
  logic [15:0] m_dly  [N];
  logic        m_en, m_upd;
  logic [3:0]  m_ch;
  logic [1:0]  m_rs;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_regbank u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata),
    .dat_we_i(dat_we), .dat_re_i(dat_re), .dat_wdata_i(dat_wdata),
    .dat_rdata_o(dat_rdata), .pwm_en_o(pwm_en),
    .duty_o(duty), .cfg_o(cfg), .dly_o(dly)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] got,
                     input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_ctl();
    return {3'b0, m_en, 3'b0, m_upd, m_ch, 2'b0, m_rs};
  endfunction

  function automatic logic [15:0] exp_rd();
    if (m_ch >= 4'd10) return 16'h0;
    if (m_rs == 2'd0)  return m_pend[m_ch];
    if (m_rs == 2'd1)  return m_cfg[m_ch];
    return m_dly[m_ch];
  endfunction

  task automatic chk_all(input string tag);
    chk(tag, "ctl_rdata", ctl_rdata, exp_ctl());
    chk(tag, "dat_rdata", dat_rdata, exp_rd());
    chk(tag, "pwm_en", {15'b0, pwm_en}, {15'b0, m_en});
    for (int i = 0; i < N; i++) begin
      chk(tag, $sformatf("duty%0d", i), duty[i*W +: W], m_act[i]);
      chk(tag, $sformatf("cfg%0d", i),  cfg[i*W +: W],  m_cfg[i]);
      chk(tag, $sformatf("dly%0d", i),  dly[i*W +: W],  m_dly[i]);
    end
  endtask

  // one clock with the given strobes; model follows the requirements
  task automatic cycle(input logic cw, input logic [15:0] cv, input logic dw,
                       input logic dr, input logic [15:0] dv);
    ctl_we = cw; ctl_wdata = cv; dat_we = dw; dat_re = dr; dat_wdata = dv;
    @(posedge clk);
    if (m_upd) for (int i = 0; i < N; i++) m_act[i] = m_pend[i];   // R5, R10
    if (dw && m_ch < 4'd10) begin                                  // R8
      if (m_rs == 2'd0)      m_pend[m_ch] = dv;                    // R4
      else if (m_rs == 2'd1) m_cfg[m_ch]  = dv;                    // R6
      else                   m_dly[m_ch]  = dv;
    end
    if (cw) begin                                                  // R2, R9
      m_en = cv[12]; m_upd = cv[8]; m_ch = cv[7:4]; m_rs = cv[1:0];
    end else begin
      m_upd = 1'b0;
      if (dw || dr) m_ch = (m_ch >= 4'd9) ? 4'd0 : m_ch + 4'd1;    // R7
    end
    #1;
    ctl_we = 1'b0; dat_we = 1'b0; dat_re = 1'b0;
  endtask

  function automatic logic [15:0] val(input int rs, input int i);
    return 16'(rs * 4099 + i * 313 + 7);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    ctl_we = 0; dat_we = 0; dat_re = 0; ctl_wdata = 0; dat_wdata = 0;
    m_en = 0; m_upd = 0; m_ch = 0; m_rs = 0;
    for (int i = 0; i < N; i++) begin
      m_pend[i] = 0; m_act[i] = 0; m_cfg[i] = 0; m_dly[i] = 0;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk_all("R1");

    // all ones: reserved bits dropped, strobe one cycle
    cycle(1, 16'hFFFF, 0, 0, 0);
    chk("R2", "ctl all ones", ctl_rdata, 16'h11F3);
    chk("R3", "en set", {15'b0, pwm_en}, 16'h1);
    chk_all("R2");
    cycle(0, 0, 0, 0, 0);
    chk("R5", "strobe cleared", ctl_rdata, 16'h10F3);
    chk_all("R5");

    // reserved channel 15: read zero, write dropped, index wraps
    chk("R8", "rsv read", dat_rdata, 16'h0);
    cycle(0, 0, 1, 0, 16'hBEEF);
    chk_all("R8");
    chk("R7", "wrap from rsv", {12'b0, ctl_rdata[7:4]}, 16'h0);

    cycle(1, 16'h0000, 0, 0, 0);
    chk("R3", "en clear", {15'b0, pwm_en}, 16'h0);

    // streamed writes and read-back for each register kind
    for (int rs = 0; rs < 3; rs++) begin
      cycle(1, 16'(rs), 0, 0, 0);
      for (int i = 0; i < N; i++) begin
        cycle(0, 0, 1, 0, val(rs, i));
        chk_all(rs == 0 ? "R4" : "R6");
      end
      chk("R7", "wrap from 9", {12'b0, ctl_rdata[7:4]}, 16'h0);
      for (int i = 0; i < N; i++) begin
        chk(rs == 0 ? "R4" : "R6", "stream read", dat_rdata, val(rs, i));
        cycle(0, 0, 0, 1, 0);
      end
      chk_all("R7");
    end

    // index 3 aliases delay
    cycle(1, 16'h0003, 0, 0, 0);
    for (int i = 0; i < N; i++) begin
      chk("R6", "alias read", dat_rdata, val(2, i));
      cycle(0, 0, 0, 1, 0);
    end
    cycle(1, 16'h0033, 0, 1, 16'h4242);
    chk_all("R6");

    // commit all pending duties
    cycle(1, 16'h1100, 0, 0, 0);
    chk("R4", "duty before commit", duty[15:0], 16'h0);
    chk_all("R5");
    cycle(0, 0, 0, 0, 0);
    chk("R5", "duty committed", duty[9*W +: W], val(0, 9));
    chk_all("R5");

    // duty write during strobe stays pending
    cycle(1, 16'h1100, 0, 0, 0);
    cycle(0, 0, 1, 0, 16'hA5A5);
    chk("R10", "old pending committed", duty[15:0], val(0, 0));
    chk_all("R10");
    cycle(1, 16'h1100, 0, 0, 0);
    cycle(0, 0, 0, 0, 0);
    chk("R10", "later commit", duty[15:0], 16'hA5A5);
    chk_all("R10");

    // control write and data access in one cycle
    cycle(1, 16'h1031, 0, 0, 0);
    cycle(1, 16'h1050, 1, 0, 16'h7777);
    chk("R9", "ctl index wins", ctl_rdata, 16'h1050);
    chk("R9", "old target cfg3", cfg[3*W +: W], 16'h7777);
    chk_all("R9");

    // read at channel 9 wraps
    cycle(1, 16'h1092, 0, 0, 0);
    cycle(0, 0, 0, 1, 0);
    chk("R7", "read wrap", {12'b0, ctl_rdata[7:4]}, 16'h0);
    chk_all("R7");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule